// File: doc/BRIEF.md
# Shadow-Buffered Period and Compare Timer

This block is an up-counter with a programmable period (TOP) and a set of compare channels. The period and each compare value have two copies: a live register that the counter uses, and a shadow copy that software may load at any moment. Loading a shadow raises a pending flag for that register. The shadow moves into the live register only when the counter reloads from TOP to zero, so a period or compare change never cuts a cycle short or produces a malformed waveform. A lock bit can hold every pending transfer back. Live registers can also be written directly when no buffering is wanted. While a transfer is pending, writes to that register pair are refused and a sticky error flag is raised.

Software uses one write port and one read port, each addressed by a small register number. Each compare channel drives a one-cycle match pulse. A separate one-cycle pulse marks every reload. When the counter is halted and the lock is clear, a pending period shadow is moved in right away, without waiting for a reload.

Top module: `dbt_timer`

## Requirements
- R1: After a synchronous reset, the count, every live register, every shadow register, the pending flags, the error flag and the lock bit all read 0, and `update_o` and `cmp_o` are low.
- R2: While `run` is high, the count rises by one each cycle. In the cycle after the count equals the live TOP, it reloads to 0. `update_o` is high for exactly that one cycle, so consecutive pulses are TOP+1 cycles apart. While `run` is low, the count holds and no pulse occurs.
- R3: A write to a shadow address loads the shadow and sets its pending flag. The pending flags read at address 6 as bit 0 for the period and bit 1+i for channel i. The live register keeps its value until a transfer happens.
- R4: On a reload with the lock clear, every pending shadow (period and all channels) is copied into its live register, and its pending flag clears.
- R5: Writing a 1 in bit 0 to address 3 sets the lock, and writing a 1 in bit 0 to address 4 clears it. The lock reads at address 5 bit 1. While the lock is set, no transfer occurs and pending flags stay set. After the lock clears, the next reload performs the transfer.
- R6: While a register's pending flag is set, a write to its live address or its shadow address changes neither register and sets the error flag (address 5 bit 0). The busy bits at address 7 use the same layout as the pending flags and are set for the same interval.
- R7: The error flag stays set until a write to address 5 with bit 0 equal to 1. A write there with bit 0 equal to 0 leaves the flag unchanged.
- R8: A write to a live address (period at 1, channel i at 8+2i) with its pending flag clear takes effect at that clock edge. If a direct write puts TOP below the current count, the counter runs past its maximum and wraps, so that one interval between pulses is 256+TOP+1 cycles.
- R9: A period written through its shadow (address 2) while running leaves the current interval at the old TOP+1. The following interval uses the new value.
- R10: With `run` low and the lock clear, a pending period shadow is copied into the live period within one cycle, with no reload. Compare shadows are not moved while the counter is halted. With the lock set, the period shadow is not moved either.
- R11: While running, `cmp_o[i]` is high for one cycle, one cycle after the count equals channel i's live compare value. That is C+1 cycles after the `update_o` pulse for a compare value C that is not above TOP.
- R12: `rd_data` shows the register chosen by `rd_addr` one clock later. The map is: 0 count, 1 live period, 2 period shadow, 5 status, 6 pending flags, 7 busy flags, 8+2i channel i live value, 9+2i channel i shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Counter enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Write register number |
| wr_data | input | CW (8) | Write value |
| rd_addr | input | AW (4) | Read register number |
| rd_data | output | CW (8) | Registered read value |
| cmp_o | output | NCH (2) | One-cycle compare-match pulse per channel |
| update_o | output | 1 | One-cycle reload pulse |

## Verification
A pending transfer normally lasts only until the next reload, so the refused-write and busy behaviour is hard to reach from the ports. The bench sets the lock first and then loads a shadow. This parks the transfer for as long as needed, so refused writes, the error flag and its clear can be exercised and read back before the lock is released. The wraparound case needs a direct TOP write that lands while the count is already above the new value. The bench waits a fixed number of cycles after a reload pulse with TOP at 200, then writes 20. It measures the lengthened interval from the cycle stamps of successive pulses.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  // register numbers shared by decode and read mux
  localparam int A_COUNT    = 0;
  localparam int A_PER      = 1;
  localparam int A_PERSHD   = 2;
  localparam int A_LOCK_SET = 3;
  localparam int A_LOCK_CLR = 4;
  localparam int A_STATUS   = 5;
  localparam int A_PEND     = 6;
  localparam int A_BUSY     = 7;
  localparam int A_CH_BASE  = 8;

  function automatic int ch_live_addr(int i);
    return A_CH_BASE + 2 * i;
  endfunction

  function automatic int ch_shd_addr(int i);
    return A_CH_BASE + 2 * i + 1;
  endfunction
endpackage

// File: rtl/dbt_counter.sv
module dbt_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] count_o,
  output logic          evt_o,
  output logic          upd_o
);
  logic [CW-1:0] cnt_q;
  logic          upd_q;

  assign evt_o = run && (cnt_q == top);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= evt_o;
      if (evt_o)
        cnt_q <= '0;
      else if (run)
        cnt_q <= cnt_q + CW'(1);
    end
  end

  assign count_o = cnt_q;
  assign upd_o   = upd_q;

  assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_q == top) |=> (cnt_q == '0 && upd_q));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == $past(cnt_q) && !upd_q));
endmodule

// File: rtl/dbt_shadow.sv
module dbt_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_live,
  input  logic         wr_buf,
  input  logic [W-1:0] wdata,
  input  logic         xfer_en,
  output logic [W-1:0] live_o,
  output logic [W-1:0] buf_o,
  output logic         valid_o,
  output logic         refused_o
);
  logic [W-1:0] live_q, buf_q;
  logic         valid_q;

  // a pending transfer owns both copies until it completes
  assign refused_o = (wr_live || wr_buf) && valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      buf_q   <= '0;
      valid_q <= 1'b0;
    end else if (valid_q) begin
      if (xfer_en) begin
        live_q  <= buf_q;
        valid_q <= 1'b0;
      end
    end else begin
      if (wr_live)
        live_q <= wdata;
      if (wr_buf) begin
        buf_q   <= wdata;
        valid_q <= 1'b1;
      end
    end
  end

  assign live_o  = live_q;
  assign buf_o   = buf_q;
  assign valid_o = valid_q;

  assert_pend_src_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(wr_buf));
  assert_xfer_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_q && xfer_en) |=> (!valid_q && live_q == $past(buf_q)));
  assert_refuse_live_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_live && valid_q && !xfer_en) |=> live_q == $past(live_q));
  assert_refuse_buf_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_buf && valid_q) |=> buf_q == $past(buf_q));
endmodule

// File: rtl/dbt_regif.sv
module dbt_regif
  import dbt_pkg::*;
#(
  parameter int CW  = 8,
  parameter int NCH = 2,
  parameter int AW  = 4,
  localparam int NREG = NCH + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic              wr_bit0,
  input  logic [AW-1:0]     rd_addr,
  output logic [CW-1:0]     rd_data,
  output logic              per_wr_live,
  output logic              per_wr_buf,
  output logic [NCH-1:0]    cc_wr_live,
  output logic [NCH-1:0]    cc_wr_buf,
  input  logic [NREG-1:0]   refused,
  input  logic [NREG-1:0]   pend,
  input  logic [CW-1:0]     count,
  input  logic [CW-1:0]     per_live,
  input  logic [CW-1:0]     per_buf,
  input  logic [NCH*CW-1:0] cc_live,
  input  logic [NCH*CW-1:0] cc_buf,
  output logic              lock_o
);
  logic          lock_q, err_q;
  logic [CW-1:0] rd_q, rd_n;
  logic          lock_set, lock_clr, err_clr;

  always_comb begin
    per_wr_live = wr_en && (wr_addr == AW'(A_PER));
    per_wr_buf  = wr_en && (wr_addr == AW'(A_PERSHD));
    for (int i = 0; i < NCH; i++) begin
      cc_wr_live[i] = wr_en && (wr_addr == AW'(ch_live_addr(i)));
      cc_wr_buf[i]  = wr_en && (wr_addr == AW'(ch_shd_addr(i)));
    end
    lock_set = wr_en && wr_bit0 && (wr_addr == AW'(A_LOCK_SET));
    lock_clr = wr_en && wr_bit0 && (wr_addr == AW'(A_LOCK_CLR));
    err_clr  = wr_en && wr_bit0 && (wr_addr == AW'(A_STATUS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (lock_set)
        lock_q <= 1'b1;
      else if (lock_clr)
        lock_q <= 1'b0;
      if (|refused)
        err_q <= 1'b1;
      else if (err_clr)
        err_q <= 1'b0;
    end
  end

  always_comb begin
    rd_n = '0;
    if (rd_addr == AW'(A_COUNT))  rd_n = count;
    if (rd_addr == AW'(A_PER))    rd_n = per_live;
    if (rd_addr == AW'(A_PERSHD)) rd_n = per_buf;
    if (rd_addr == AW'(A_STATUS)) rd_n = CW'({lock_q, err_q});
    if (rd_addr == AW'(A_PEND))   rd_n = CW'(pend);
    if (rd_addr == AW'(A_BUSY))   rd_n = CW'(pend);
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == AW'(ch_live_addr(i))) rd_n = cc_live[i*CW +: CW];
      if (rd_addr == AW'(ch_shd_addr(i)))  rd_n = cc_buf[i*CW +: CW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_n;
  end

  assign rd_data = rd_q;
  assign lock_o  = lock_q;

  assert_lock_set_R5: assert property (@(posedge clk) disable iff (rst)
    lock_set |=> lock_q);
  assert_lock_clr_R5: assert property (@(posedge clk) disable iff (rst)
    lock_clr |=> !lock_q);
  assert_err_on_refuse_R6: assert property (@(posedge clk) disable iff (rst)
    (|refused) |=> err_q);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> err_q);
endmodule

// File: rtl/dbt_timer.sv
module dbt_timer #(
  parameter int CW  = 8,
  parameter int NCH = 2,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [CW-1:0]  rd_data,
  output logic [NCH-1:0] cmp_o,
  output logic           update_o
);
  localparam int NREG = NCH + 1;

  logic [CW-1:0]     count, per_live, per_buf;
  logic [NCH*CW-1:0] cc_live, cc_buf;
  logic [NREG-1:0]   pend, refused;
  logic              per_wr_live, per_wr_buf;
  logic [NCH-1:0]    cc_wr_live, cc_wr_buf;
  logic              evt, lock, per_xfer, ch_xfer;

  // period also follows its shadow while halted; channels only on reload
  assign per_xfer = !lock && (evt || !run);
  assign ch_xfer  = !lock && evt;

  dbt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .top(per_live),
    .count_o(count), .evt_o(evt), .upd_o(update_o)
  );

  dbt_shadow #(.W(CW)) u_per (
    .clk(clk), .rst(rst), .wr_live(per_wr_live), .wr_buf(per_wr_buf),
    .wdata(wr_data), .xfer_en(per_xfer), .live_o(per_live),
    .buf_o(per_buf), .valid_o(pend[0]), .refused_o(refused[0])
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit_q;

    dbt_shadow #(.W(CW)) u_cc (
      .clk(clk), .rst(rst), .wr_live(cc_wr_live[g]), .wr_buf(cc_wr_buf[g]),
      .wdata(wr_data), .xfer_en(ch_xfer), .live_o(cc_live[g*CW +: CW]),
      .buf_o(cc_buf[g*CW +: CW]), .valid_o(pend[g+1]), .refused_o(refused[g+1])
    );

    always_ff @(posedge clk) begin
      if (rst) hit_q <= 1'b0;
      else     hit_q <= run && (count == cc_live[g*CW +: CW]);
    end

    assign cmp_o[g] = hit_q;

    assert_cmp_running_R11: assert property (@(posedge clk) disable iff (rst)
      hit_q |-> $past(run));
  end

  dbt_regif #(.CW(CW), .NCH(NCH), .AW(AW)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bit0(wr_data[0]), .rd_addr(rd_addr), .rd_data(rd_data),
    .per_wr_live(per_wr_live), .per_wr_buf(per_wr_buf),
    .cc_wr_live(cc_wr_live), .cc_wr_buf(cc_wr_buf),
    .refused(refused), .pend(pend), .count(count),
    .per_live(per_live), .per_buf(per_buf),
    .cc_live(cc_live), .cc_buf(cc_buf), .lock_o(lock)
  );

  assert_update_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    update_o |=> !update_o || $past(per_live) == '0);
endmodule

// File: tb/dbt_timer_test.sv
module dbt_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] cmp_o;
  logic       update_o;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, n_up = 0, last_up = 0, prev_up = 0, last_cmp0 = -100;
  bit done = 0;

  dbt_timer uut (
    .clk(clk), .rst(rst), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmp_o(cmp_o), .update_o(update_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (update_o) begin
      prev_up = last_up;
      last_up = cyc;
      n_up    = n_up + 1;
    end
    if (cmp_o[0]) last_cmp0 = cyc;
  end

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    rd_addr = 4'(a);
    @(posedge clk);
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic wait_up();
    int n0 = n_up;
    int guard = 0;
    do begin
      @(negedge clk); #1;
      guard++;
    end while (n_up == n0 && guard < 2000);
    if (guard >= 2000) chk("R2 pulse timeout", 0, 1);
  endtask

  task automatic t_reset();
    int v;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 update_o", int'(update_o), 0);
    chk("R1 cmp_o", int'(cmp_o), 0);
    rd(0, v); chk("R1 count", v, 0);
    rd(1, v); chk("R1 period", v, 0);
    rd(2, v); chk("R1 period shadow", v, 0);
    rd(5, v); chk("R1 status", v, 0);
    rd(6, v); chk("R1 pending", v, 0);
    rd(9, v); chk("R1 ch0 shadow", v, 0);
  endtask

  task automatic t_direct();
    int v;
    wr(1, 9);
    rd(1, v); chk("R8 R12 direct period", v, 9);
    wr(8, 5);
    rd(8, v); chk("R8 R12 direct ch0", v, 5);
    rd(6, v); chk("R8 direct sets no pending", v, 0);
  endtask

  task automatic t_period();
    int a, b;
    @(negedge clk) run = 1'b1;
    wait_up();
    wait_up();
    chk("R2 interval TOP+1", last_up - prev_up, 10);
    repeat (8) @(negedge clk);
    chk("R11 compare offset", last_cmp0 - last_up, 6);
    @(negedge clk) run = 1'b0;
    rd(0, a);
    repeat (3) @(negedge clk);
    rd(0, b);
    chk("R2 count holds when halted", b, a);
  endtask

  task automatic t_buffered();
    int v;
    @(negedge clk) run = 1'b1;
    wr(1, 19);
    wait_up();
    wait_up();
    chk("R8 direct period interval", last_up - prev_up, 20);
    wr(2, 24);
    wr(11, 3);
    rd(6, v); chk("R3 pending bits", v, 5);
    rd(1, v); chk("R3 live period kept", v, 19);
    rd(10, v); chk("R3 live ch1 kept", v, 0);
    wait_up();
    chk("R9 old interval kept", last_up - prev_up, 20);
    rd(1, v); chk("R4 period moved", v, 24);
    rd(10, v); chk("R4 ch1 moved", v, 3);
    rd(6, v); chk("R4 pending cleared", v, 0);
    wait_up();
    chk("R9 new interval", last_up - prev_up, 25);
  endtask

  task automatic t_lock();
    int v;
    wr(3, 1);
    rd(5, v); chk("R5 lock reads set", v, 2);
    wr(2, 6);
    wait_up();
    wait_up();
    rd(1, v); chk("R5 no transfer while locked", v, 24);
    rd(6, v); chk("R5 pending stays", v, 1);
    wr(1, 30);
    wr(2, 7);
    rd(5, v); chk("R6 error raised", v, 3);
    rd(7, v); chk("R6 busy bits", v, 1);
    rd(2, v); chk("R6 shadow unchanged", v, 6);
    rd(1, v); chk("R6 live unchanged", v, 24);
    wr(5, 0);
    rd(5, v); chk("R7 error sticky", v, 3);
    wr(5, 1);
    rd(5, v); chk("R7 error cleared", v, 2);
    wr(4, 1);
    rd(5, v); chk("R5 lock cleared", v, 0);
    wait_up();
    rd(1, v); chk("R5 transfer after unlock", v, 6);
    rd(6, v); chk("R5 pending cleared after unlock", v, 0);
    wait_up();
    wait_up();
    chk("R5 interval after unlock", last_up - prev_up, 7);
  endtask

  task automatic t_wrap();
    wr(1, 200);
    wait_up();
    wait_up();
    chk("R8 interval 200", last_up - prev_up, 201);
    repeat (100) @(negedge clk);
    wr(1, 20);
    wait_up();
    chk("R8 wraparound interval", last_up - prev_up, 277);
    wait_up();
    chk("R8 interval after wrap", last_up - prev_up, 21);
  endtask

  task automatic t_halted();
    int v, n0;
    @(negedge clk) run = 1'b0;
    repeat (2) @(negedge clk);
    n0 = n_up;
    wr(2, 33);
    @(negedge clk);
    rd(1, v); chk("R10 halted period copy", v, 33);
    rd(6, v); chk("R10 pending cleared halted", v, 0);
    chk("R10 no reload pulse", n_up, n0);
    wr(9, 9);
    repeat (3) @(negedge clk);
    rd(8, v); chk("R10 ch0 not moved halted", v, 5);
    rd(6, v); chk("R10 ch0 pending", v, 2);
    wr(3, 1);
    wr(2, 44);
    repeat (3) @(negedge clk);
    rd(1, v); chk("R10 locked halted no copy", v, 33);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    chk("watchdog", 0, 1);
    finish_run();
  end

  initial begin
    t_reset();
    t_direct();
    t_period();
    t_buffered();
    t_lock();
    t_wrap();
    t_halted();
    finish_run();
  end
endmodule